// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into a stream of per-element memory requests. A command gives a base byte address, an element width, an addressing mode, a signed stride, a vector length, an optional per-element flag vector and a sign-extension attribute for loads. The generator walks the elements in increasing order. For each element that is enabled and correctly aligned, it presents one request with the byte address, the element number and a byte-enable pattern for an 8-byte memory lane. The request is held until the memory side accepts it.

There are three addressing modes. Unit stride steps by the element size. Constant stride steps by a signed byte count. Indexed mode adds a per-element signed offset to the base. That offset is fetched through a small lookup port, which is addressed by the current element number and answered in the same cycle.

Control is one state machine with three states:
- `ST_IDLE` accepts a command. It moves to `ST_WALK`, or to `ST_FINISH` when the length is zero.
- `ST_WALK` handles one element per cycle, or per accepted request. Each element is skipped, flagged as misaligned, or issued. After the last element the machine moves to `ST_FINISH`.
- `ST_FINISH` pulses `done` for one cycle and returns to `ST_IDLE`.

Top module: `vaddr_gen`

## Requirements
- R1: Unit-stride mode (`cmd_mode`=0, and the unused code 3) gives element i the address base + i*size, where size is 1, 2, 4 or 8 bytes for `cmd_width` codes 0, 1, 2, 3.
- R2: Constant-stride mode (`cmd_mode`=1) gives element i the address base + i*stride. The stride is a two's-complement byte count, so negative strides walk downward.
- R3: Indexed mode (`cmd_mode`=2) gives element i the address base + `idx_value`, with `idx_value` read while `idx_elem` equals i.
- R4: `req_be` has size consecutive ones, shifted left by the low three address bits. Bit b stands for byte b of the 8-byte lane.
- R5: With `cmd_masked`=1, an element whose bit in `cmd_mask` (bit i for element i) is 0 produces no request and no error. With `cmd_masked`=0 the flag bits have no effect.
- R6: Elements 0 to L-1 are handled in increasing order, and each request carries its element number on `req_elem`. L is `cmd_vlen`, clamped to MAX_VL (64).
- R7: A command with `cmd_vlen`=0 issues nothing. `done` rises in the cycle right after the command is accepted.
- R8: An enabled element whose address is not a multiple of size produces no request. Instead it pulses `err_valid` for one cycle with its number on `err_elem`. Masked-off elements never raise this error.
- R9: While `req_valid` is high and `req_ready` is low, the request address and element number stay unchanged.
- R10: `done` is high for exactly one cycle, in the cycle after the last element is handled. `cmd_ready` is low from command acceptance through the `done` cycle, and high again in the next cycle.
- R11: Every request carries the command's sign-extension attribute on `req_signed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command taken when valid |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_width | input | 2 | Element width code (0:1B, 1:2B, 2:4B, 3:8B) |
| cmd_mode | input | 2 | 0 unit, 1 constant stride, 2 indexed |
| cmd_stride | input | ADDR_W | Signed byte stride |
| cmd_vlen | input | VL_W | Vector length |
| cmd_masked | input | 1 | Use per-element flags |
| cmd_mask | input | MAX_VL | Per-element enable flags |
| cmd_signed | input | 1 | Sign-extend attribute for loads |
| idx_elem | output | EL_W | Element whose offset is requested |
| idx_value | input | ADDR_W | Signed offset for `idx_elem` |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts request |
| req_addr | output | ADDR_W | Element byte address |
| req_elem | output | EL_W | Element number |
| req_be | output | 8 | Lane byte enables |
| req_signed | output | 1 | Sign-extend attribute |
| err_valid | output | 1 | Misaligned element pulse |
| err_elem | output | EL_W | Number of misaligned element |
| done | output | 1 | Command finished (one cycle) |

## Verification
Flag suppression and the alignment check can both apply to the same element. The case of interest is a masked-off element whose address is also misaligned, and there flag suppression must win. The bench provokes this in indexed mode: one offset table holds odd offsets, and some of those sit at elements whose flag is 0. It then expects neither a request nor an error for those elements. The same misaligned elements must still raise errors when the flags are disabled. Each request or error event is compared in order against a list computed from the command.

// File: rtl/vag_pkg.sv
package vag_pkg;
    typedef enum logic [1:0] {
        EW_B8  = 2'd0,
        EW_B16 = 2'd1,
        EW_B32 = 2'd2,
        EW_B64 = 2'd3
    } ew_t;

    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RSVD   = 2'd3
    } am_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } st_t;

    localparam int LANE_BYTES = 8;
endpackage

// File: rtl/vag_addr.sv
module vag_addr
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANE_B = LANE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [1:0]        cmd_width,
    input  logic [1:0]        cmd_mode,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic              advance,
    input  logic [ADDR_W-1:0] idx_value,
    output logic [ADDR_W-1:0] addr,
    output logic              misaligned,
    output logic [LANE_B-1:0] be
);
    localparam int OFF_W = $clog2(LANE_B);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] acc_q;
    logic [ADDR_W-1:0] step_q;
    logic [1:0]        width_q;
    logic              index_q;

    logic [3:0]        size_b;
    logic [ADDR_W-1:0] align_mask;
    logic [LANE_B:0]   ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            acc_q   <= '0;
            step_q  <= '0;
            width_q <= '0;
            index_q <= 1'b0;
        end else if (load) begin
            base_q  <= cmd_base;
            acc_q   <= cmd_base;
            width_q <= cmd_width;
            index_q <= (cmd_mode == AM_INDEX);
            if (cmd_mode == AM_STRIDE)
                step_q <= cmd_stride;
            else
                step_q <= ADDR_W'(1) << cmd_width;
        end else if (advance) begin
            acc_q <= acc_q + step_q;
        end
    end

    always_comb begin
        size_b     = 4'd1 << width_q;
        align_mask = ADDR_W'(size_b) - ADDR_W'(1);
        addr       = index_q ? (base_q + idx_value) : acc_q;
        misaligned = |(addr & align_mask);
        ones       = ((LANE_B+1)'(1) << size_b) - (LANE_B+1)'(1);
        be         = ones[LANE_B-1:0] << addr[OFF_W-1:0];
    end

    // R4: an aligned element enables exactly size bytes
    assert_be_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !misaligned |-> ($countones(be) == int'(size_b)));
endmodule

// File: rtl/vag_ctrl.sv
module vag_ctrl
    import vag_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int EL_W   = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [VL_W-1:0]   cmd_vlen,
    input  logic              cmd_masked,
    input  logic [MAX_VL-1:0] cmd_mask,
    output logic              cmd_ready,
    output logic              load,
    input  logic              misaligned,
    input  logic              req_ready,
    output logic              req_valid,
    output logic              err_valid,
    output logic [EL_W-1:0]   cur_elem,
    output logic              advance,
    output logic              done
);
    st_t               state_q, state_d;
    logic [EL_W-1:0]   elem_q;
    logic [VL_W-1:0]   vlen_q;
    logic              masked_q;
    logic [MAX_VL-1:0] mask_q;

    logic [VL_W-1:0]   vlen_eff;
    logic              flag_on;
    logic              last;

    assign vlen_eff = (cmd_vlen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cmd_vlen;
    assign flag_on  = !masked_q || mask_q[elem_q];
    assign last     = (VL_W'(elem_q) == (vlen_q - VL_W'(1)));
    assign cur_elem = elem_q;

    // state register and per-command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            elem_q   <= '0;
            vlen_q   <= '0;
            masked_q <= 1'b0;
            mask_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                elem_q   <= '0;
                vlen_q   <= vlen_eff;
                masked_q <= cmd_masked;
                mask_q   <= cmd_mask;
            end else if (advance && !last) begin
                elem_q <= elem_q + EL_W'(1);
            end
        end
    end

    // outputs and transitions
    always_comb begin
        state_d   = state_q;
        cmd_ready = 1'b0;
        load      = 1'b0;
        req_valid = 1'b0;
        err_valid = 1'b0;
        advance   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    load    = 1'b1;
                    state_d = (vlen_eff == '0) ? ST_FINISH : ST_WALK;
                end
            end
            ST_WALK: begin
                if (!flag_on) begin
                    advance = 1'b1;
                end else if (misaligned) begin
                    err_valid = 1'b1;
                    advance   = 1'b1;
                end else begin
                    req_valid = 1'b1;
                    advance   = req_ready;
                end
                if (advance && last)
                    state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && cmd_ready);

    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_vlen == '0) |=> done);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid || (cur_elem != $past(cur_elem)));
endmodule

// File: rtl/vaddr_gen.sv
module vaddr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int EL_W   = $clog2(MAX_VL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_base,
    input  logic [1:0]            cmd_width,
    input  logic [1:0]            cmd_mode,
    input  logic [ADDR_W-1:0]     cmd_stride,
    input  logic [VL_W-1:0]       cmd_vlen,
    input  logic                  cmd_masked,
    input  logic [MAX_VL-1:0]     cmd_mask,
    input  logic                  cmd_signed,
    output logic [EL_W-1:0]       idx_elem,
    input  logic [ADDR_W-1:0]     idx_value,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [ADDR_W-1:0]     req_addr,
    output logic [EL_W-1:0]       req_elem,
    output logic [LANE_BYTES-1:0] req_be,
    output logic                  req_signed,
    output logic                  err_valid,
    output logic [EL_W-1:0]       err_elem,
    output logic                  done
);
    logic            load;
    logic            advance;
    logic            misaligned;
    logic [EL_W-1:0] cur_elem;
    logic            signed_q;

    vag_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .EL_W(EL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_vlen   (cmd_vlen),
        .cmd_masked (cmd_masked),
        .cmd_mask   (cmd_mask),
        .cmd_ready  (cmd_ready),
        .load       (load),
        .misaligned (misaligned),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .err_valid  (err_valid),
        .cur_elem   (cur_elem),
        .advance    (advance),
        .done       (done)
    );

    vag_addr #(.ADDR_W(ADDR_W), .LANE_B(LANE_BYTES)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cmd_base   (cmd_base),
        .cmd_width  (cmd_width),
        .cmd_mode   (cmd_mode),
        .cmd_stride (cmd_stride),
        .advance    (advance),
        .idx_value  (idx_value),
        .addr       (req_addr),
        .misaligned (misaligned),
        .be         (req_be)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            signed_q <= 1'b0;
        else if (load)
            signed_q <= cmd_signed;
    end

    assign idx_elem   = cur_elem;
    assign req_elem   = cur_elem;
    assign err_elem   = cur_elem;
    assign req_signed = signed_q;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_elem));

    assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid || (req_elem > $past(req_elem)));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || err_valid) |-> !cmd_ready);
endmodule

// File: tb/test_vaddr_gen.sv
module test_vaddr_gen;
    localparam int ADDR_W = 32;
    localparam int MAX_VL = 64;
    localparam int VL_W   = 7;
    localparam int EL_W   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [1:0]        cmd_width = '0;
    logic [1:0]        cmd_mode = '0;
    logic [ADDR_W-1:0] cmd_stride = '0;
    logic [VL_W-1:0]   cmd_vlen = '0;
    logic              cmd_masked = 1'b0;
    logic [MAX_VL-1:0] cmd_mask = '0;
    logic              cmd_signed = 1'b0;
    logic [EL_W-1:0]   idx_elem;
    logic [ADDR_W-1:0] idx_value;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic [EL_W-1:0]   req_elem;
    logic [7:0]        req_be;
    logic              req_signed;
    logic              err_valid;
    logic [EL_W-1:0]   err_elem;
    logic              done;

    logic [ADDR_W-1:0] idx_tab [MAX_VL];
    assign idx_value = idx_tab[idx_elem];

    always #10 clk = ~clk;

    vaddr_gen i_vaddr_gen (.*);

    int n_chk = 0;
    int n_bad = 0;

    int          exp_n;
    int          exp_kind [MAX_VL];
    int          exp_elem [MAX_VL];
    logic [31:0] exp_addr [MAX_VL];
    logic [7:0]  exp_be   [MAX_VL];
    bit          exp_tail;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input logic [31:0] base, input int w, input int mode,
                             input logic [31:0] stride, input int vlen,
                             input bit masked, input logic [63:0] mask);
        int lim = (vlen > MAX_VL) ? MAX_VL : vlen;
        int sz = 1 << w;
        exp_n = 0;
        exp_tail = 1'b0;
        for (int i = 0; i < lim; i++) begin
            logic [31:0] a;
            if (masked && !mask[i]) continue;
            if (mode == 1)      a = base + stride * i;
            else if (mode == 2) a = base + idx_tab[i];
            else                a = base + i * sz;
            exp_elem[exp_n] = i;
            exp_addr[exp_n] = a;
            exp_be[exp_n]   = 8'(((1 << sz) - 1) << a[2:0]);
            exp_kind[exp_n] = ((a % sz) != 0) ? 2 : 1;
            exp_n++;
            if (i == lim - 1) exp_tail = 1'b1;
        end
    endtask

    // rdy: 0 always ready, 1 stall every third cycle, 2 ready every other cycle
    task automatic run_cmd(input string req, input logic [31:0] base, input int w,
                           input int mode, input logic [31:0] stride, input int vlen,
                           input bit masked, input logic [63:0] mask,
                           input bit sgn, input int rdy);
        int k = 0;
        int cyc = 0;
        int last_evt = -10;
        bit seen_done = 1'b0;
        bit stall = 1'b0;
        logic [31:0] st_addr = '0;
        int st_elem = 0;
        build_exp(base, w, mode, stride, vlen, masked, mask);
        @(negedge clk);
        cmd_base = base; cmd_width = 2'(w); cmd_mode = 2'(mode); cmd_stride = stride;
        cmd_vlen = 7'(vlen); cmd_masked = masked; cmd_mask = mask; cmd_signed = sgn;
        cmd_valid = 1'b1;
        #1;
        check(cmd_ready, "R10", "ready before command", longint'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!seen_done && cyc < 400) begin
            cyc++;
            req_ready = (rdy == 0) ? 1'b1 : (rdy == 1) ? ((cyc % 3) != 2) : ((cyc % 2) == 0);
            #1;
            if (stall) begin
                check(req_valid && req_addr == st_addr && int'(req_elem) == st_elem, "R9",
                      "held request", longint'(req_addr), longint'(st_addr));
            end
            stall = req_valid && !req_ready;
            st_addr = req_addr;
            st_elem = int'(req_elem);
            if (req_valid && req_ready) begin
                if (k < exp_n) begin
                    check(exp_kind[k] == 1, req, "unexpected request", longint'(req_elem), exp_elem[k]);
                    check(int'(req_elem) == exp_elem[k], "R6", "request element", longint'(req_elem), exp_elem[k]);
                    check(req_addr == exp_addr[k], req, "address", longint'(req_addr), longint'(exp_addr[k]));
                    check(req_be == exp_be[k], "R4", "byte enables", longint'(req_be), longint'(exp_be[k]));
                    check(req_signed == sgn, "R11", "sign attribute", longint'(req_signed), longint'(sgn));
                end else begin
                    check(1'b0, "R5", "extra request", longint'(req_elem), -1);
                end
                k++; last_evt = cyc;
            end
            if (err_valid) begin
                if (k < exp_n) begin
                    check(exp_kind[k] == 2 && int'(err_elem) == exp_elem[k], "R8", "error element",
                          longint'(err_elem), exp_elem[k]);
                end else begin
                    check(1'b0, "R8", "extra error", longint'(err_elem), -1);
                end
                k++; last_evt = cyc;
            end
            if (done) begin
                seen_done = 1'b1;
                check(k == exp_n, "R6", "event count", k, exp_n);
                check(!cmd_ready, "R10", "ready during done", longint'(cmd_ready), 0);
                if (vlen == 0)
                    check(cyc == 1, "R7", "zero length done cycle", cyc, 1);
                if (exp_tail)
                    check(cyc == last_evt + 1, "R10", "done after last element", cyc, last_evt + 1);
            end
            @(negedge clk);
        end
        check(seen_done, "R10", "done seen", longint'(seen_done), 1);
        #1;
        check(cmd_ready && !done, "R10", "idle after done", longint'(cmd_ready), 1);
        req_ready = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check(cmd_ready && !req_valid && !err_valid && !done, "R10", "reset state",
              {cmd_ready, req_valid, err_valid, done}, 4'b1000);
    endtask

    task automatic t_unit_word();
        run_cmd("R1", 32'h1000, 2, 0, 0, 8, 0, '0, 1'b0, 0);
    endtask

    task automatic t_unit_byte_stall();
        run_cmd("R1", 32'h2003, 0, 0, 0, 10, 0, '0, 1'b1, 1);
    endtask

    task automatic t_unit_half_slow();
        run_cmd("R1", 32'h3002, 1, 3, 0, 7, 0, '0, 1'b0, 2);
    endtask

    task automatic t_stride_negative();
        run_cmd("R2", 32'h4000, 1, 1, -32'sd24, 6, 0, '0, 1'b1, 0);
    endtask

    task automatic t_stride_misalign();
        run_cmd("R8", 32'h8000, 3, 1, 32'd12, 5, 0, '0, 1'b0, 1);
    endtask

    task automatic t_index_masked();
        for (int i = 0; i < MAX_VL; i++)
            idx_tab[i] = (i % 3 == 1) ? 32'(i * 8 + 1) : 32'(i * 4) - 32'd64;
        // elements 1, 4, 7 are misaligned and masked off; 10 is misaligned and enabled
        run_cmd("R3", 32'h100, 2, 2, 0, 12, 1, 64'b1100_0110_1101, 1'b0, 1);
    endtask

    task automatic t_index_unmasked();
        run_cmd("R5", 32'h100, 2, 2, 0, 12, 0, 64'b1100_0110_1101, 1'b1, 0);
    endtask

    task automatic t_zero_length();
        run_cmd("R7", 32'h500, 2, 0, 0, 0, 0, '0, 1'b0, 0);
    endtask

    task automatic t_clamp_length();
        run_cmd("R6", 32'h9000, 3, 0, 0, 100, 0, '0, 1'b0, 0);
    endtask

    task automatic t_mask_tail();
        run_cmd("R5", 32'hA000, 0, 1, 32'd3, 9, 1, 64'h0AA, 1'b0, 2);
    endtask

    initial begin
        for (int i = 0; i < MAX_VL; i++) idx_tab[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unit_word();
        t_unit_byte_stall();
        t_unit_half_slow();
        t_stride_negative();
        t_stride_misalign();
        t_index_masked();
        t_index_unmasked();
        t_zero_length();
        t_clamp_length();
        t_mask_tail();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule